// File: doc/BRIEF.md
# HDLC Receive Status and Interrupt Register Bank

This block holds the status and interrupt registers for one receive HDLC channel. The receive datapath supplies two kinds of input. Live conditions (FIFO not empty, FIFO above its high watermark, and a three-bit code for the current packet's outcome) are shown as they are, with no history. Single-cycle event pulses are caught in sticky bits that stay at 1 until software clears them.

Software reaches the bank through a byte-wide port with a two-bit address, a read strobe and a write strobe. A write to the event register clears each sticky bit that has a 1 in its position in the written byte. A mask register selects which sticky events may pull the shared active-low interrupt line. A small two-state machine drives that line from a flop: IRQ_QUIET (line high) and IRQ_ACTIVE (line low). The transition RAISE (QUIET to ACTIVE) is taken when any sticky bit that is also unmasked is set. The transition RELEASE (ACTIVE to QUIET) is taken when no such bit remains. In every other case the machine holds its state.

Top module: `hdlc_rx_status_irq`

## Requirements
- R1: After reset, all sticky event bits are 0, the mask is 0 (every event masked), irq_n_o is 1 and reg_rdata_o is 0. Reset is asynchronous and active low.
- R2: reg_rdata_o is loaded on the clock edge that samples reg_rd_i high, and it holds its value while no read is strobed. At address 0 the byte is: bit 0 = FIFO not empty, bit 1 = above watermark, bits 6:4 = packet code (0 in progress, 1 good, 2 CRC error, 3 abort, 4 overrun), and bits 7, 3 and 2 = 0.
- R3: A 1 on evt_i[i] sets sticky bit i, which is read at address 1 bit i. The bit stays 1 after the pulse ends.
- R4: A write to address 1 clears each sticky bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R5: When an event pulse and a clearing write reach the same bit in the same cycle, the bit ends up 1.
- R6: A write to address 0 has no effect. The live byte read afterwards still reflects the inputs.
- R7: The mask is written and read at address 2, with bit i gating event i. Bits 7:6 read as 0.
- R8: irq_n_o goes low on the second clock edge after an unmasked event pulse is sampled. An event whose mask bit is 0 does not drive irq_n_o low.
- R9: irq_n_o stays low while any unmasked sticky bit is set. It goes high on the second clock edge after the write that clears the last one.
- R10: Address 3 reads as 0, and sticky-register bits 7:6 read as 0.
- R11: Setting the mask bit of a sticky bit that is already set drives irq_n_o low, and clearing that mask bit lets irq_n_o go high, with the same two-edge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT | Event pulses, one bit per sticky event |
| fifo_nonempty_i | input | 1 | Live: receive FIFO holds data |
| fifo_above_wm_i | input | 1 | Live: receive FIFO above its watermark |
| pkt_status_i | input | 3 | Live packet outcome code |
| reg_addr_i | input | 2 | Register address |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
A wrong sticky bit shows up in the byte read from address 1 on the edge after the read. Two edges later it also shows on irq_n_o as a spurious low or a missing low, if its mask bit is set. A machine stuck in the wrong state keeps irq_n_o at the wrong level, and this is visible two edges after any change to the pending set. The bench therefore samples irq_n_o both one and two edges after each event, mask change and clear, so that a slip of one cycle is caught as well.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
    localparam int REG_ADDR_W = 2;
    localparam int PKT_W      = 3;

    // live byte layout
    localparam int LIVE_NE_BIT  = 0;
    localparam int LIVE_WM_BIT  = 1;
    localparam int LIVE_PKT_LSB = 4;

    typedef enum logic [REG_ADDR_W-1:0] {
        ADDR_LIVE  = 2'd0,
        ADDR_EVENT = 2'd1,
        ADDR_MASK  = 2'd2,
        ADDR_SPARE = 2'd3
    } reg_addr_e;

    typedef enum logic [PKT_W-1:0] {
        PKT_BUSY    = 3'd0,
        PKT_GOOD    = 3'd1,
        PKT_BAD_CRC = 3'd2,
        PKT_ABORTED = 3'd3,
        PKT_OVERRUN = 3'd4
    } pkt_code_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/hsi_live_status.sv
module hsi_live_status #(
    parameter int DATA_W = 8
) (
    input  logic                       nonempty_i,
    input  logic                       above_wm_i,
    input  logic [hsi_pkg::PKT_W-1:0]  pkt_i,
    output logic [DATA_W-1:0]          live_o
);
    import hsi_pkg::*;

    always_comb begin
        live_o                                = '0;
        live_o[LIVE_NE_BIT]                   = nonempty_i;
        live_o[LIVE_WM_BIT]                   = above_wm_i;
        live_o[LIVE_PKT_LSB +: PKT_W]         = pkt_i;
    end
endmodule

// File: rtl/hsi_event_latch.sv
module hsi_event_latch #(
    parameter int NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] clr_i,
    output logic [NUM_EVT-1:0] q_o
);
    // one sticky cell per event; a new event outranks a clear
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_o[g] <= 1'b0;
            else if (evt_i[g])
                q_o[g] <= 1'b1;
            else if (clr_i[g])
                q_o[g] <= 1'b0;
        end
    end

    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((q_o & $past(evt_i)) == $past(evt_i)));

    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o != '0) |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i)));

    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~evt_i) != '0) |=> ((q_o & $past(clr_i & ~evt_i)) == '0));

    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & evt_i) != '0) |=> ((q_o & $past(clr_i & evt_i)) == $past(clr_i & evt_i)));
endmodule

// File: rtl/hsi_irq_fsm.sv
module hsi_irq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any_i,
    output logic int_n_o
);
    import hsi_pkg::*;

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pend_any_i)  state_d = IRQ_ACTIVE;  // RAISE
            IRQ_ACTIVE: if (!pend_any_i) state_d = IRQ_QUIET;   // RELEASE
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        int_n_o = (state_q != IRQ_ACTIVE);
    end

    a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any_i |=> !int_n_o);

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_any_i |=> int_n_o);
endmodule

// File: rtl/hdlc_rx_status_irq.sv
module hdlc_rx_status_irq #(
    parameter int NUM_EVT = 6,
    parameter int DATA_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_EVT-1:0]             evt_i,
    input  logic                           fifo_nonempty_i,
    input  logic                           fifo_above_wm_i,
    input  logic [hsi_pkg::PKT_W-1:0]      pkt_status_i,
    input  logic [hsi_pkg::REG_ADDR_W-1:0] reg_addr_i,
    input  logic                           reg_rd_i,
    input  logic                           reg_wr_i,
    input  logic [DATA_W-1:0]              reg_wdata_i,
    output logic [DATA_W-1:0]              reg_rdata_o,
    output logic                           irq_n_o
);
    import hsi_pkg::*;

    reg_addr_e          addr;
    logic [DATA_W-1:0]  live_byte;
    logic [NUM_EVT-1:0] sticky;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] pending;
    logic [DATA_W-1:0]  rd_word;

    assign addr    = reg_addr_e'(reg_addr_i);
    assign clr_vec = (reg_wr_i && addr == ADDR_EVENT) ? reg_wdata_i[NUM_EVT-1:0] : '0;
    assign pending = sticky & mask_q;

    hsi_live_status #(.DATA_W(DATA_W)) live_i (
        .nonempty_i (fifo_nonempty_i),
        .above_wm_i (fifo_above_wm_i),
        .pkt_i      (pkt_status_i),
        .live_o     (live_byte)
    );

    hsi_event_latch #(.NUM_EVT(NUM_EVT)) latch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .clr_i (clr_vec),
        .q_o   (sticky)
    );

    hsi_irq_fsm irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_any_i (|pending),
        .int_n_o    (irq_n_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_wr_i && addr == ADDR_MASK)
            mask_q <= reg_wdata_i[NUM_EVT-1:0];
    end

    always_comb begin
        rd_word = '0;
        unique case (addr)
            ADDR_LIVE:  rd_word = live_byte;
            ADDR_EVENT: rd_word[NUM_EVT-1:0] = sticky;
            ADDR_MASK:  rd_word[NUM_EVT-1:0] = mask_q;
            ADDR_SPARE: rd_word = '0;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_rdata_o <= '0;
        else if (reg_rd_i)
            reg_rdata_o <= rd_word;
    end

    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> $stable(reg_rdata_o));

    a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd2) |=> (mask_q == $past(reg_wdata_i[NUM_EVT-1:0])));

    a_r10_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == 2'd3) |=> (reg_rdata_o == '0));
endmodule

// File: tb/hdlc_rx_status_irq_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_status_irq_tb_top;
    localparam int NV = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt = '0;
    logic       ne = 1'b0, wm = 1'b0;
    logic [2:0] pkt = '0;
    logic [1:0] addr = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hdlc_rx_status_irq dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .fifo_nonempty_i(ne), .fifo_above_wm_i(wm), .pkt_status_i(pkt),
        .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_n_o(irq_n)
    );

    // {wr, rd, addr[2], wdata[8], evt[6], ne, wm, pkt[3], chk_rd, exp_rd[8], exp_irq_n}
    localparam logic [32:0] VEC [NV] = '{
        {1'b0,1'b1,2'd0,8'h00,6'h00,1'b1,1'b0,3'd2,1'b1,8'h21,1'b1}, // 0  R2
        {1'b0,1'b1,2'd0,8'h00,6'h00,1'b0,1'b1,3'd4,1'b1,8'h42,1'b1}, // 1  R2
        {1'b1,1'b0,2'd0,8'hFF,6'h00,1'b1,1'b1,3'd3,1'b0,8'h00,1'b1}, // 2  R6 write live
        {1'b0,1'b1,2'd0,8'h00,6'h00,1'b1,1'b1,3'd3,1'b1,8'h33,1'b1}, // 3  R6
        {1'b0,1'b0,2'd0,8'h00,6'h05,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1}, // 4  R8 masked
        {1'b0,1'b1,2'd1,8'h00,6'h00,1'b0,1'b0,3'd0,1'b1,8'h05,1'b1}, // 5  R3
        {1'b1,1'b0,2'd2,8'hFF,6'h00,1'b0,1'b0,3'd0,1'b0,8'h00,1'b0}, // 6  R11 unmask
        {1'b0,1'b1,2'd2,8'h00,6'h00,1'b0,1'b0,3'd0,1'b1,8'h3F,1'b0}, // 7  R7
        {1'b1,1'b0,2'd1,8'h01,6'h00,1'b0,1'b0,3'd0,1'b0,8'h00,1'b0}, // 8  R9
        {1'b0,1'b1,2'd1,8'h00,6'h00,1'b0,1'b0,3'd0,1'b1,8'h04,1'b0}, // 9  R4
        {1'b1,1'b0,2'd1,8'h04,6'h00,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1}, // 10 R9
        {1'b0,1'b1,2'd1,8'h00,6'h00,1'b0,1'b0,3'd0,1'b1,8'h00,1'b1}, // 11 R4
        {1'b1,1'b0,2'd2,8'h02,6'h00,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1}, // 12 R7
        {1'b0,1'b0,2'd0,8'h00,6'h08,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1}, // 13 R8 masked
        {1'b0,1'b0,2'd0,8'h00,6'h02,1'b0,1'b0,3'd0,1'b0,8'h00,1'b0}, // 14 R8
        {1'b1,1'b0,2'd1,8'hF0,6'h00,1'b0,1'b0,3'd0,1'b0,8'h00,1'b0}, // 15 R4 zeros keep
        {1'b0,1'b1,2'd1,8'h00,6'h00,1'b0,1'b0,3'd0,1'b1,8'h0A,1'b0}, // 16 R4
        {1'b0,1'b1,2'd3,8'h00,6'h00,1'b0,1'b0,3'd0,1'b1,8'h00,1'b0}, // 17 R10
        {1'b1,1'b0,2'd2,8'h00,6'h00,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1}, // 18 R11 mask off
        {1'b0,1'b1,2'd1,8'h00,6'h00,1'b0,1'b0,3'd0,1'b1,8'h0A,1'b1}, // 19 R3
        {1'b1,1'b0,2'd1,8'h3F,6'h00,1'b0,1'b0,3'd0,1'b0,8'h00,1'b1}, // 20 R4
        {1'b0,1'b1,2'd1,8'h00,6'h00,1'b0,1'b0,3'd0,1'b1,8'h00,1'b1}  // 21 R4
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 1:           return "R2";
            2, 3:           return "R6";
            4, 13, 14:      return "R8";
            5, 19:          return "R3";
            6, 18:          return "R11";
            7, 12:          return "R7";
            8, 10:          return "R9";
            17:             return "R10";
            default:        return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_n == 1'b1, "R1 irq", 32'(irq_n), 1);
        chk(rdata == 8'h00, "R1 rdata", 32'(rdata), 0);
        do_rd(2'd1);
        chk(rdata == 8'h00, "R1 sticky", 32'(rdata), 0);
        do_rd(2'd2);
        chk(rdata == 8'h00, "R1 mask", 32'(rdata), 0);

        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            v = VEC[i];
            @(negedge clk);
            wr = v[32]; rd = v[31]; addr = v[30:29]; wdata = v[28:21];
            evt = v[20:15]; ne = v[14]; wm = v[13]; pkt = v[12:10];
            @(negedge clk);
            wr = 1'b0; rd = 1'b0; evt = '0;
            @(negedge clk);
            if (v[9]) chk(rdata == v[8:1], vec_req(i), 32'(rdata), 32'(v[8:1]));
            chk(irq_n == v[0], vec_req(i), 32'(irq_n), 32'(v[0]));
        end

        // R8 exact latency
        do_wr(2'd2, 8'h01);
        @(negedge clk); evt = 6'h01;
        @(negedge clk); evt = '0;
        chk(irq_n == 1'b1, "R8 one edge", 32'(irq_n), 1);
        @(negedge clk);
        chk(irq_n == 1'b0, "R8 two edges", 32'(irq_n), 0);

        // R9 exact latency
        @(negedge clk); wr = 1'b1; addr = 2'd1; wdata = 8'h01;
        @(negedge clk); wr = 1'b0;
        chk(irq_n == 1'b0, "R9 one edge", 32'(irq_n), 0);
        @(negedge clk);
        chk(irq_n == 1'b1, "R9 two edges", 32'(irq_n), 1);

        // R2 read latency and hold
        ne = 1'b1; pkt = 3'd1;
        do_rd(2'd1);
        @(negedge clk); rd = 1'b1; addr = 2'd0;
        #1 chk(rdata == 8'h00, "R2 before edge", 32'(rdata), 0);
        @(negedge clk); rd = 1'b0;
        chk(rdata == 8'h11, "R2 after edge", 32'(rdata), 32'h11);
        ne = 1'b0; pkt = 3'd0;
        @(negedge clk); @(negedge clk);
        chk(rdata == 8'h11, "R2 hold", 32'(rdata), 32'h11);

        // R5 event and clear in one cycle
        @(negedge clk); wr = 1'b1; addr = 2'd1; wdata = 8'h10; evt = 6'h10;
        @(negedge clk); wr = 1'b0; evt = '0;
        do_rd(2'd1);
        chk(rdata == 8'h10, "R5 event wins", 32'(rdata), 32'h10);
        do_wr(2'd1, 8'h10);
        do_rd(2'd1);
        chk(rdata == 8'h00, "R4 cleared", 32'(rdata), 0);

        // R1 reset mid-run
        @(negedge clk); evt = 6'h01;
        @(negedge clk); evt = '0;
        @(negedge clk);
        chk(irq_n == 1'b0, "R8 before reset", 32'(irq_n), 0);
        rst_n = 1'b0;
        #1 chk(irq_n == 1'b1, "R1 async irq", 32'(irq_n), 1);
        @(negedge clk); rst_n = 1'b1;
        do_rd(2'd2);
        chk(rdata == 8'h00, "R1 mask after reset", 32'(rdata), 0);
        do_rd(2'd1);
        chk(rdata == 8'h00, "R1 sticky after reset", 32'(rdata), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule